// File: doc/BRIEF.md
# SMBus Alert Response Target

This block is the alert side of a two-wire bus target. A one-cycle pulse on `alert_req` latches a pending fault and pulls the open-drain `alert_n` line low. The host then reads the broadcast alert response address, 0001100 with the read/write bit set. Every target with a pending fault acknowledges that read and shifts its own 7-bit address onto SDA.

Several targets can answer the same read. They settle it with ordinary wired-AND arbitration. A target that leaves SDA released but sees it low has lost. It stops driving, raises `arb_lost` and keeps its alert asserted, so it answers again on a later read. The target that sends its last bit without losing clears its pending fault and releases `alert_n`.

SCL and SDA are oversampled by the system clock through a synchroniser. SDA is driven only low, through `sda_oe`.

Top module: `smb_alert_target`

## Requirements
- R1: After reset, `alert_n` is 1, `sda_oe` is 0 and `arb_lost` is 0.
- R2: A pulse on `alert_req` drives `alert_n` low at the next clock edge, and it stays low while the fault is pending.
- R3: With a fault pending, a read of address 0001100 (R/W bit = 1, sent MSB first) is acknowledged: SDA is low in the ninth clock slot.
- R4: With no fault pending, the same read gets no acknowledge (SDA stays high in the ninth slot).
- R5: A byte with any other address, or 0001100 with R/W bit = 0, gets no acknowledge even when a fault is pending.
- R6: After the acknowledge, the target sends its parameter address MSB first in the next seven SCL slots, then one trailing 1 bit, changing SDA only while SCL is low.
- R7: If no bit is lost in arbitration, `alert_n` returns high after the trailing bit, and it never rises otherwise.
- R8: If the target releases SDA but samples it low, it stops driving for the rest of the transfer and sets `arb_lost` until the next START. `alert_n` stays low, and a later read from the host is answered again.
- R9: A START or STOP in the middle of a transfer returns the bit engine to idle and keeps the pending fault.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| alert_req | input | 1 | One-cycle fault request pulse |
| alert_n | output | 1 | Alert line, low while a fault is pending |
| sda_oe | output | 1 | Drives SDA low when 1 |
| arb_lost | output | 1 | Set after arbitration was lost, cleared at START |

## Verification
Some properties are checked on every cycle:
- the alert falls right after a request;
- the alert rises only in the cycle after a won transfer;
- the data driver moves only while SCL is low;
- an acknowledge is driven only with a fault pending;
- a lost bit leaves the line released.

Other behaviour only the bench scenarios can show:
- the exact bit pattern on the shared line;
- the refusal of other addresses and of the write direction;
- recovery after an aborted byte;
- a second answer after a lost round against a competing responder with a lower address.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;
  localparam int BYTE_BITS = 8;
  localparam logic [6:0] ARA_ADDR = 7'b0001100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_PEND,
    ST_ACK,
    ST_SEND,
    ST_SKIP
  } bus_state_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_alert_latch.sv
module smb_alert_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_win,
  output logic pending,
  output logic alert_n
);
  logic pend_nxt;

  always_comb begin
    pend_nxt = pending;
    if (clr_win) pend_nxt = 1'b0;
    if (set_req) pend_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      alert_n <= 1'b1;
    end else begin
      pending <= pend_nxt;
      alert_n <= ~pend_nxt;
    end
  end

  assert_alert_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    set_req |=> !alert_n);
endmodule

// File: rtl/smb_alert_fsm.sv
module smb_alert_fsm
  import smb_alert_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h45
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic pending,
  output logic sda_oe,
  output logic win,
  output logic arb_lost
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS - 1);
  localparam logic [BYTE_BITS-1:0] ARA_READ = {ARA_ADDR, 1'b1};

  bus_state_t state;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_BITS-1:0] rx_sh, tx_sh, rx_nxt;

  assign rx_nxt = {rx_sh[BYTE_BITS-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      sda_oe   <= 1'b0;
      win      <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      win <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        arb_lost <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: if (scl_rise) begin
            rx_sh <= rx_nxt;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST)
              state <= (rx_nxt == ARA_READ && pending) ? ST_ACK_PEND : ST_SKIP;
          end
          ST_ACK_PEND: if (scl_fall) begin
            sda_oe <= 1'b1;
            state  <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            tx_sh  <= {OWN_ADDR[5:0], 2'b10};
            sda_oe <= ~OWN_ADDR[6];
            cnt    <= '0;
            state  <= ST_SEND;
          end
          ST_SEND: begin
            if (scl_rise) begin
              if (!sda_oe && !sda_s) begin
                arb_lost <= 1'b1;
                state    <= ST_SKIP;
              end else if (cnt == LAST) begin
                win   <= 1'b1;
                state <= ST_SKIP;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else if (scl_fall) begin
              sda_oe <= ~tx_sh[BYTE_BITS-1];
              tx_sh  <= tx_sh << 1;
            end
          end
          ST_SKIP: if (scl_fall) sda_oe <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);
  assert_ack_needs_pending_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && state == ST_ACK) |-> pending);
  assert_lost_released_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_lost) |-> !sda_oe);
endmodule

// File: rtl/smb_alert_target.sv
module smb_alert_target #(
  parameter logic [6:0] OWN_ADDR    = 7'h45,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic alert_req,
  output logic alert_n,
  output logic sda_oe,
  output logic arb_lost
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic pending, win;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_alert_latch u_latch (
    .clk(clk), .rst(rst), .set_req(alert_req), .clr_win(win),
    .pending(pending), .alert_n(alert_n)
  );

  smb_alert_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .pending(pending),
    .sda_oe(sda_oe), .win(win), .arb_lost(arb_lost)
  );

  assert_release_after_win_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_n) |-> $past(win));
endmodule

// File: tb/test_smb_alert_target.sv
module test_smb_alert_target;
  localparam logic [6:0] OWN = 7'h45;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, m_sda = 1'b1, o_sda = 1'b1, alert_req = 1'b0;
  logic alert_n, sda_oe, arb_lost, bus_sda;
  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  assign bus_sda = m_sda & o_sda & ~sda_oe;

  smb_alert_target #(.OWN_ADDR(OWN)) i_smb_alert_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda),
    .alert_req(alert_req), .alert_n(alert_n), .sda_oe(sda_oe), .arb_lost(arb_lost)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic m, input logic o, output logic seen);
    m_sda = m; o_sda = o;
    wait_n(H); scl = 1'b1;
    wait_n(H); seen = bus_sda;
    scl = 1'b0; wait_n(2);
  endtask

  // Monitor side of the scoreboard: pop and compare one expected bit.
  task automatic mon(input logic seen);
    logic e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    chk(t, seen, e);
  endtask

  task automatic do_start();
    m_sda = 1'b1; o_sda = 1'b1; wait_n(H);
    scl = 1'b1; wait_n(H);
    m_sda = 1'b0; wait_n(H);
    scl = 1'b0; wait_n(2);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; o_sda = 1'b1; wait_n(H);
    scl = 1'b1; wait_n(H);
    m_sda = 1'b1; wait_n(H);
  endtask

  task automatic pulse_alert();
    alert_req = 1'b1; wait_n(1);
    alert_req = 1'b0;
  endtask

  // Address byte plus acknowledge slot; o_ack models a competing acknowledger.
  task automatic send_byte(input logic [7:0] b, input logic o_ack,
                           input logic exp_ack, input string tag);
    logic s;
    for (int i = 0; i < 8; i++) bit_cycle(b[7-i], 1'b1, s);
    exp_q.push_back(exp_ack); tag_q.push_back(tag);
    bit_cycle(1'b1, o_ack, s);
    mon(s);
  endtask

  // Read the responder address bits; comp_on adds a competing responder.
  task automatic read_addr(input bit comp_on, input logic [6:0] comp, input string tag);
    logic s, ours, c, lost;
    logic [7:0] cw, ow;
    lost = 1'b0;
    cw = {comp, 1'b1};
    ow = {OWN, 1'b1};
    for (int i = 0; i < 8; i++) begin
      ours = lost ? 1'b1 : ow[7-i];
      c = comp_on ? cw[7-i] : 1'b1;
      exp_q.push_back(ours & c); tag_q.push_back(tag);
      bit_cycle(1'b1, c, s);
      mon(s);
      if (lost) chk("R8 no drive after loss", sda_oe, 1'b0);
      if (!lost && ours && !c) lost = 1'b1;
    end
    bit_cycle(1'b1, 1'b1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    chk("R1 alert_n", alert_n, 1'b1);
    chk("R1 sda_oe", sda_oe, 1'b0);
    chk("R1 arb_lost", arb_lost, 1'b0);

    pulse_alert();
    chk("R2 alert low", alert_n, 1'b0);
    wait_n(20);
    chk("R2 alert held", alert_n, 1'b0);

    do_start();
    send_byte(8'b0001_1001, 1'b1, 1'b0, "R3 ack");
    read_addr(1'b0, 7'h0, "R6 address bit");
    do_stop();
    chk("R7 alert released", alert_n, 1'b1);
    chk("R7 no loss", arb_lost, 1'b0);

    do_start();
    send_byte(8'b0001_1001, 1'b1, 1'b1, "R4 no ack when idle");
    do_stop();

    pulse_alert();
    do_start();
    send_byte(8'b0001_1000, 1'b1, 1'b1, "R5 write dir no ack");
    do_stop();
    do_start();
    send_byte(8'b0101_0101, 1'b1, 1'b1, "R5 other addr no ack");
    do_stop();
    chk("R5 alert still low", alert_n, 1'b0);

    do_start();
    begin
      logic s;
      for (int i = 0; i < 4; i++) bit_cycle(i == 3, 1'b1, s);
    end
    do_start();
    do_stop();
    chk("R9 pending kept", alert_n, 1'b0);
    do_start();
    send_byte(8'b0001_1001, 1'b1, 1'b0, "R9 ack after abort");
    read_addr(1'b1, 7'h40, "R8 arbitration bus");
    chk("R8 lost flag", arb_lost, 1'b1);
    do_stop();
    chk("R8 alert held", alert_n, 1'b0);

    do_start();
    chk("R8 flag cleared at start", arb_lost, 1'b0);
    send_byte(8'b0001_1001, 1'b1, 1'b0, "R8 answers again");
    read_addr(1'b0, 7'h0, "R6 resend bit");
    do_stop();
    chk("R7 released after win", alert_n, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule